// File: doc/BRIEF.md
# Reverse Zig-Zag Coefficient Statistics Unit

This block gathers the run-level statistics that a context-adaptive variable-length residual coder needs from one 4x4 block of quantized transform coefficients. The whole block is presented in raster order on a wide input bus and captured when `start_i` is sampled high. The unit then visits the coefficients one per clock cycle in reverse zig-zag order, from the highest-frequency scan position down to DC.

During this single walk it counts the nonzero coefficients, the trailing unit-magnitude coefficients and the zeros lying below the highest nonzero coefficient. It also fills three result buffers: the signs of the trailing ones, the remaining nonzero levels, and the zero run in front of each nonzero coefficient. Every list is written in reverse scan order, which is the order in which a downstream codeword stage consumes it. A one-cycle `done_o` pulse marks the end of the walk. All results then stay unchanged until the next accepted start.

Top module: `rzz_coef_stats`

## Requirements
- R1: The raster input element at row r, column c sits at `coef_i[(4*r+c)*COEF_W +: COEF_W]` as a two's-complement value. Scan position k maps to raster index 0,1,4,8,5,2,3,6,9,12,13,10,7,11,14,15 for k = 0..15. The walk runs from k = 15 down to k = 0, and every output list holds its entries in this walk order, with entry 0 first.
- R2: `tc_o` equals the number of nonzero coefficients in the block.
- R3: `t1_o` counts the consecutive coefficients of magnitude 1 met first on the walk, and saturates at 3. A unit coefficient met after the count reaches 3, or after any other nonzero value has been met, is treated as an ordinary level.
- R4: Bit i of `t1_sign_o` is the sign of the i-th trailing one on the walk, where 1 means negative. Bits at or above `t1_o` read 0.
- R5: Each nonzero coefficient that is not a trailing one is stored in walk order in `lvl_o` slot j, at bits `[j*COEF_W +: COEF_W]`. `lvl_cnt_o` gives the number stored, which equals `tc_o - t1_o`. Unused slots read 0.
- R6: `t0_o` equals the number of zero coefficients at scan positions below the highest-positioned nonzero coefficient.
- R7: Slot i of `run_o`, at bits `[4*i +: 4]`, holds the number of zeros between the i-th nonzero coefficient on the walk and the next nonzero one below it. `run_cnt_o` gives how many slots are meaningful: it counts slots from i = 0 while i < `tc_o - 1` and zeros remain to be assigned. All other slots read 0.
- R8: An all-zero block reports zero for every count, leaves every buffer at 0, and still produces the `done_o` pulse.
- R9: `done_o` is high for exactly one cycle, at the 16th rising edge after the edge that samples `start_i`. A start seen while a walk is in progress is ignored. Outputs do not change from the done pulse until the next accepted start, even if `coef_i` changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Capture the block and begin a walk (accepted when idle) |
| coef_i | input | 256 | Sixteen signed coefficients in raster order |
| done_o | output | 1 | One-cycle pulse at the end of the walk |
| tc_o | output | 5 | Nonzero coefficient count |
| t1_o | output | 2 | Trailing-one count |
| t0_o | output | 5 | Zeros below the highest nonzero coefficient |
| t1_sign_o | output | 3 | Trailing-one signs, 1 = negative |
| lvl_o | output | 256 | Level buffer, walk order |
| lvl_cnt_o | output | 5 | Number of stored levels |
| run_o | output | 64 | Zero-run buffer, walk order |
| run_cnt_o | output | 5 | Number of meaningful zero runs |

## Verification
The walk is tried with several kinds of block, each chosen to separate one statistic from the others. The all-zero block and a DC-only block exercise the empty and shortest cases. A lone coefficient at the last scan position gives the largest possible zero count and no runs. A fully populated block gives no zeros and a full level buffer. Four unit coefficients at the tail show the trailing-one count saturating, and a large value placed between unit coefficients shows that the count stops early. A mixed-sign block with large magnitudes checks sign capture and level order. A second start issued in the middle of a walk, and an input change after done, show that results belong only to the captured block.

// File: rtl/rzz_pkg.sv
package rzz_pkg;

   typedef enum logic {
      ST_IDLE,
      ST_WALK
   } walk_st_e;

   // Raster index of zig-zag scan position k for a dim x dim block.
   // Diagonals are walked alternately down-left (odd) and up-right (even).
   function automatic int zz_to_raster(input int k, input int dim);
      int seen;
      int res;
      int r;
      int c;
      seen = 0;
      res  = 0;
      for (int d = 0; d < 2*dim-1; d++) begin
         for (int s = 0; s < dim; s++) begin
            r = (d % 2 == 1) ? s : (dim - 1 - s);
            c = d - r;
            if (c >= 0 && c < dim) begin
               if (seen == k) res = r*dim + c;
               seen++;
            end
         end
      end
      return res;
   endfunction

endpackage

// File: rtl/rzz_walk_ctrl.sv
module rzz_walk_ctrl #(
   parameter int NC = 16,
   localparam int PW = $clog2(NC)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          start_i,
   output logic          load_o,
   output logic          walk_o,
   output logic [PW-1:0] pos_o,
   output logic          done_o
);
   import rzz_pkg::*;

   walk_st_e      st_q;
   logic [PW-1:0] pos_q;
   logic          done_q;

   assign walk_o = (st_q == ST_WALK);
   assign load_o = (st_q == ST_IDLE) && start_i;
   assign pos_o  = pos_q;
   assign done_o = done_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= ST_IDLE;
         pos_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= walk_o && (pos_q == '0);
         if (load_o) begin
            st_q  <= ST_WALK;
            pos_q <= PW'(NC-1);
         end else if (walk_o) begin
            if (pos_q == '0) st_q  <= ST_IDLE;
            else             pos_q <= pos_q - 1'b1;
         end
      end
   end

endmodule

// File: rtl/rzz_coef_pick.sv
module rzz_coef_pick #(
   parameter int BLK_DIM = 4,
   parameter int COEF_W  = 16,
   localparam int NC     = BLK_DIM*BLK_DIM,
   localparam int PW     = $clog2(NC)
) (
   input  logic [NC*COEF_W-1:0] blk_i,
   input  logic [PW-1:0]        pos_i,
   output logic [COEF_W-1:0]    coef_o
);
   logic [COEF_W-1:0] scan_w [NC];

   for (genvar k = 0; k < NC; k++) begin : g_scan
      localparam int RI = rzz_pkg::zz_to_raster(k, BLK_DIM);
      assign scan_w[k] = blk_i[RI*COEF_W +: COEF_W];
   end

   assign coef_o = scan_w[pos_i];

endmodule

// File: rtl/rzz_stat_acc.sv
module rzz_stat_acc #(
   parameter int NC      = 16,
   parameter int COEF_W  = 16,
   parameter int T1_MAX  = 3,
   localparam int CW     = $clog2(NC+1),
   localparam int RW     = $clog2(NC),
   localparam int TW     = $clog2(T1_MAX+1)
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 clear_i,
   input  logic                 step_i,
   input  logic [COEF_W-1:0]    coef_i,
   output logic [CW-1:0]        tc_o,
   output logic [TW-1:0]        t1_o,
   output logic [CW-1:0]        t0_o,
   output logic [T1_MAX-1:0]    t1_sign_o,
   output logic [NC*COEF_W-1:0] lvl_o,
   output logic [CW-1:0]        lvl_cnt_o,
   output logic [NC*RW-1:0]     run_o,
   output logic [CW-1:0]        run_cnt_o
);
   logic [CW-1:0]     nz_q, t0_q, lvl_n_q, run_n_q;
   logic [TW-1:0]     t1_q;
   logic              stop_q;
   logic [RW-1:0]     zrun_q;
   logic [T1_MAX-1:0] sign_q;
   logic [COEF_W-1:0] lvl_q [NC];
   logic [RW-1:0]     run_q [NC];

   logic is_nz, is_unit, take_t1;

   assign is_nz   = (coef_i != '0);
   assign is_unit = (coef_i == COEF_W'(1)) || (coef_i == {COEF_W{1'b1}});
   assign take_t1 = is_nz && is_unit && !stop_q && (t1_q < TW'(T1_MAX));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         nz_q <= '0; t1_q <= '0; t0_q <= '0; lvl_n_q <= '0; run_n_q <= '0;
         zrun_q <= '0; stop_q <= 1'b0; sign_q <= '0;
         for (int i = 0; i < NC; i++) begin
            lvl_q[i] <= '0;
            run_q[i] <= '0;
         end
      end else if (clear_i) begin
         nz_q <= '0; t1_q <= '0; t0_q <= '0; lvl_n_q <= '0; run_n_q <= '0;
         zrun_q <= '0; stop_q <= 1'b0; sign_q <= '0;
         for (int i = 0; i < NC; i++) begin
            lvl_q[i] <= '0;
            run_q[i] <= '0;
         end
      end else if (step_i) begin
         if (is_nz) begin
            if (take_t1) begin
               sign_q[t1_q] <= coef_i[COEF_W-1];
               t1_q         <= t1_q + 1'b1;
            end else begin
               stop_q                  <= 1'b1;
               lvl_q[lvl_n_q[RW-1:0]]  <= coef_i;
               lvl_n_q                 <= lvl_n_q + 1'b1;
            end
            if (nz_q != '0) run_q[RW'(nz_q - 1'b1)] <= zrun_q;
            zrun_q <= '0;
            nz_q   <= nz_q + 1'b1;
         end else if (nz_q != '0) begin
            zrun_q  <= zrun_q + 1'b1;
            t0_q    <= t0_q + 1'b1;
            run_n_q <= nz_q;
         end
      end
   end

   for (genvar i = 0; i < NC; i++) begin : g_flat
      assign lvl_o[i*COEF_W +: COEF_W] = lvl_q[i];
      assign run_o[i*RW +: RW]         = run_q[i];
   end

   always_comb begin
      if (nz_q == '0)                       run_cnt_o = '0;
      else if (run_n_q > nz_q - 1'b1)       run_cnt_o = nz_q - 1'b1;
      else                                  run_cnt_o = run_n_q;
   end

   assign tc_o      = nz_q;
   assign t1_o      = t1_q;
   assign t0_o      = t0_q;
   assign t1_sign_o = sign_q;
   assign lvl_cnt_o = lvl_n_q;

endmodule

// File: rtl/rzz_coef_stats.sv
module rzz_coef_stats #(
   parameter int BLK_DIM = 4,
   parameter int COEF_W  = 16,
   parameter int T1_MAX  = 3,
   localparam int NC     = BLK_DIM*BLK_DIM,
   localparam int CW     = $clog2(NC+1),
   localparam int RW     = $clog2(NC),
   localparam int TW     = $clog2(T1_MAX+1),
   localparam int PW     = $clog2(NC)
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 start_i,
   input  logic [NC*COEF_W-1:0] coef_i,
   output logic                 done_o,
   output logic [CW-1:0]        tc_o,
   output logic [TW-1:0]        t1_o,
   output logic [CW-1:0]        t0_o,
   output logic [T1_MAX-1:0]    t1_sign_o,
   output logic [NC*COEF_W-1:0] lvl_o,
   output logic [CW-1:0]        lvl_cnt_o,
   output logic [NC*RW-1:0]     run_o,
   output logic [CW-1:0]        run_cnt_o
);
   if (BLK_DIM < 2) begin : g_bad_dim
      $error("rzz_coef_stats: BLK_DIM must be at least 2");
   end
   if (COEF_W < 2) begin : g_bad_w
      $error("rzz_coef_stats: COEF_W must be at least 2");
   end
   if (T1_MAX < 1 || T1_MAX > NC) begin : g_bad_t1
      $error("rzz_coef_stats: T1_MAX out of range");
   end

   logic                 load, walk;
   logic [PW-1:0]        pos;
   logic [NC*COEF_W-1:0] blk_q;
   logic [COEF_W-1:0]    cur_coef;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   blk_q <= '0;
      else if (load) blk_q <= coef_i;
   end

   rzz_walk_ctrl #(.NC(NC)) i_ctrl (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .start_i(start_i),
      .load_o (load),
      .walk_o (walk),
      .pos_o  (pos),
      .done_o (done_o)
   );

   rzz_coef_pick #(.BLK_DIM(BLK_DIM), .COEF_W(COEF_W)) i_pick (
      .blk_i (blk_q),
      .pos_i (pos),
      .coef_o(cur_coef)
   );

   rzz_stat_acc #(.NC(NC), .COEF_W(COEF_W), .T1_MAX(T1_MAX)) i_acc (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clear_i  (load),
      .step_i   (walk),
      .coef_i   (cur_coef),
      .tc_o     (tc_o),
      .t1_o     (t1_o),
      .t0_o     (t0_o),
      .t1_sign_o(t1_sign_o),
      .lvl_o    (lvl_o),
      .lvl_cnt_o(lvl_cnt_o),
      .run_o    (run_o),
      .run_cnt_o(run_cnt_o)
   );

endmodule

// File: rtl/rzz_coef_stats_chk.sv
module rzz_coef_stats_chk #(
   parameter int NC     = 16,
   parameter int T1_MAX = 3,
   localparam int CW    = $clog2(NC+1),
   localparam int TW    = $clog2(T1_MAX+1)
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          start_i,
   input logic          walk_i,
   input logic          done_o,
   input logic [CW-1:0] tc_o,
   input logic [TW-1:0] t1_o,
   input logic [CW-1:0] t0_o,
   input logic [CW-1:0] lvl_cnt_o,
   input logic [CW-1:0] run_cnt_o
);
   // R9: done lasts one cycle
   a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   // R9: done only follows a walk cycle
   a_r9_done_after_walk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(done_o) |-> $past(walk_i));

   // R9: results held while idle without a start
   a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!walk_i && !start_i) |=> ($stable(tc_o) && $stable(t1_o) && $stable(t0_o)
                                 && $stable(lvl_cnt_o) && $stable(run_cnt_o)));

   // R3: trailing-one count saturates and never exceeds the nonzero count
   a_r3_t1_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (int'(t1_o) <= T1_MAX && int'(t1_o) <= int'(tc_o)));

   // R5: levels and trailing ones partition the nonzero coefficients
   a_r5_lvl_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (int'(lvl_cnt_o) + int'(t1_o) == int'(tc_o)));

   // R6: zeros and nonzeros fit in the block
   a_r6_t0_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (int'(tc_o) + int'(t0_o) <= NC));

   // R7: at most tc-1 runs
   a_r7_run_cnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && tc_o != '0) |-> (run_cnt_o < tc_o));

   // R8: empty block
   a_r8_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && tc_o == '0) |-> (t0_o == '0 && t1_o == '0 && run_cnt_o == '0));

endmodule

bind rzz_coef_stats rzz_coef_stats_chk #(.NC(NC), .T1_MAX(T1_MAX)) i_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .start_i  (start_i),
   .walk_i   (walk),
   .done_o   (done_o),
   .tc_o     (tc_o),
   .t1_o     (t1_o),
   .t0_o     (t0_o),
   .lvl_cnt_o(lvl_cnt_o),
   .run_cnt_o(run_cnt_o)
);

// File: tb/test_rzz_coef_stats.sv
`timescale 1ns/1ps
module test_rzz_coef_stats;
   localparam int NC = 16;
   localparam int W  = 16;

   logic          clk_i = 1'b0;
   logic          rst_ni = 1'b0;
   logic          start_i = 1'b0;
   logic [255:0]  coef_i = '0;
   logic          done_o;
   logic [4:0]    tc_o, t0_o, lvl_cnt_o, run_cnt_o;
   logic [1:0]    t1_o;
   logic [2:0]    t1_sign_o;
   logic [255:0]  lvl_o;
   logic [63:0]   run_o;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   int zz [16] = '{0,1,4,8,5,2,3,6,9,12,13,10,7,11,14,15};

   logic [4:0]   e_tc, e_t0, e_lvl_cnt, e_run_cnt;
   logic [1:0]   e_t1;
   logic [2:0]   e_sign;
   logic [255:0] e_lvl;
   logic [63:0]  e_run;
   logic [255:0] blk;

   always #4 clk_i = ~clk_i;

   rzz_coef_stats i_rzz_coef_stats (
      .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .coef_i(coef_i),
      .done_o(done_o), .tc_o(tc_o), .t1_o(t1_o), .t0_o(t0_o),
      .t1_sign_o(t1_sign_o), .lvl_o(lvl_o), .lvl_cnt_o(lvl_cnt_o),
      .run_o(run_o), .run_cnt_o(run_cnt_o)
   );

   task automatic chk(input string req, input string what,
                      input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic void put(input int k, input int v);
      blk[zz[k]*W +: W] = W'(v);
   endfunction

   // Reference model from the requirements
   task automatic model(input logic [255:0] b);
      int s [16];
      int vals [16];
      int poss [16];
      int n, top, zl, nl;
      e_tc = '0; e_t0 = '0; e_t1 = '0; e_sign = '0; e_lvl = '0; e_run = '0;
      e_lvl_cnt = '0; e_run_cnt = '0;
      for (int k = 0; k < 16; k++) s[k] = int'($signed(b[zz[k]*W +: W]));
      n = 0; top = -1;
      for (int k = 15; k >= 0; k--) begin
         if (s[k] != 0) begin
            if (top < 0) top = k;
            vals[n] = s[k]; poss[n] = k; n++;
         end
      end
      e_tc = 5'(n);
      for (int k = 0; k < top; k++) if (s[k] == 0) e_t0 = e_t0 + 1'b1;
      while (int'(e_t1) < n && e_t1 < 2'd3 && (vals[e_t1] == 1 || vals[e_t1] == -1)) begin
         e_sign[e_t1] = (vals[e_t1] < 0);
         e_t1 = e_t1 + 1'b1;
      end
      nl = 0;
      for (int i = int'(e_t1); i < n; i++) begin
         e_lvl[nl*W +: W] = W'(vals[i]);
         nl++;
      end
      e_lvl_cnt = 5'(nl);
      zl = int'(e_t0);
      for (int i = 0; i < n-1; i++) begin
         if (zl > 0) begin
            e_run[i*4 +: 4] = 4'(poss[i] - poss[i+1] - 1);
            zl = zl - (poss[i] - poss[i+1] - 1);
            e_run_cnt = e_run_cnt + 1'b1;
         end
      end
   endtask

   task automatic compare(input string tag);
      chk("R2", {tag, " tc"}, 256'(tc_o), 256'(e_tc));
      chk("R3", {tag, " t1"}, 256'(t1_o), 256'(e_t1));
      chk("R6", {tag, " t0"}, 256'(t0_o), 256'(e_t0));
      chk("R4", {tag, " sign"}, 256'(t1_sign_o), 256'(e_sign));
      chk("R1", {tag, " levels"}, lvl_o, e_lvl);
      chk("R5", {tag, " lvl_cnt"}, 256'(lvl_cnt_o), 256'(e_lvl_cnt));
      chk("R7", {tag, " runs"}, 256'(run_o), 256'(e_run));
      chk("R7", {tag, " run_cnt"}, 256'(run_cnt_o), 256'(e_run_cnt));
   endtask

   task automatic walk_block(input logic [255:0] a, input bit inject,
                             input logic [255:0] b, input string tag);
      int cnt;
      model(a);
      @(negedge clk_i); coef_i = a; start_i = 1'b1;
      @(negedge clk_i); start_i = 1'b0; cnt = 0;
      while (!done_o && cnt < 40) begin
         @(negedge clk_i); cnt++;
         if (inject && cnt == 5) begin coef_i = b; start_i = 1'b1; end
         else start_i = 1'b0;
      end
      chk("R9", {tag, " done cycle"}, 256'(cnt), 256'(16));
      compare(tag);
      @(negedge clk_i);
      chk("R9", {tag, " done pulse"}, 256'(done_o), 256'(0));
   endtask

   task automatic t_reset();
      chk("R9", "reset done", 256'(done_o), 256'(0));
      chk("R8", "reset tc", 256'(tc_o), 256'(0));
      chk("R8", "reset buffers", lvl_o | 256'(run_o), 256'(0));
   endtask

   task automatic t_all_zero();
      blk = '0;
      walk_block(blk, 1'b0, '0, "R8 all-zero");
   endtask

   task automatic t_dc_only();
      blk = '0; put(0, -4);
      walk_block(blk, 1'b0, '0, "dc-only");
   endtask

   task automatic t_mixed();
      blk = '0;
      put(1, 3); put(3, 1); put(4, -1); put(5, -1); put(7, 1); put(0, 0);
      walk_block(blk, 1'b0, '0, "mixed");
   endtask

   task automatic t_four_ones();
      blk = '0;
      put(2, 1); put(5, -1); put(9, 1); put(12, -1);
      walk_block(blk, 1'b0, '0, "R3 saturate");
   endtask

   task automatic t_big_break();
      blk = '0;
      put(14, -1); put(10, 5); put(3, -1); put(1, 1);
      walk_block(blk, 1'b0, '0, "R3 break");
   endtask

   task automatic t_full();
      blk = '0;
      for (int k = 0; k < 16; k++) put(k, (k % 2 == 0) ? (k + 2) : -(k + 2));
      walk_block(blk, 1'b0, '0, "full");
   endtask

   task automatic t_top_only();
      blk = '0; put(15, -7);
      walk_block(blk, 1'b0, '0, "R6 top-only");
   endtask

   task automatic t_neg_levels();
      blk = '0;
      put(0, -300); put(4, -1); put(6, 2000); put(7, 1); put(11, -1); put(13, -32768);
      walk_block(blk, 1'b0, '0, "R4 signs");
   endtask

   task automatic t_start_ignored();
      logic [255:0] other;
      blk = '0; put(2, 9); put(8, -1);
      other = '0;
      for (int i = 0; i < 16; i++) other[i*W +: W] = 16'd1;
      walk_block(blk, 1'b1, other, "R9 start-ignored");
   endtask

   task automatic t_hold();
      blk = '0; put(6, 2); put(9, 1); put(11, -1);
      walk_block(blk, 1'b0, '0, "R9 hold");
      coef_i = {16{16'h0003}};
      repeat (5) @(negedge clk_i);
      compare("R9 hold after input change");
   endtask

   initial begin
      repeat (3) @(negedge clk_i);
      t_reset();
      rst_ni = 1'b1;
      @(negedge clk_i);
      t_all_zero();
      t_dc_only();
      t_mixed();
      t_four_ones();
      t_big_break();
      t_full();
      t_top_only();
      t_neg_levels();
      t_start_ignored();
      t_hold();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk_i);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         failures++;
         $display("FAIL R9 watchdog actual=hung expected=complete");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule